// File: doc/BRIEF.md
# I2C GPIO Expander with Change Interrupt

This block is an I2C-bus target that gives a host sixteen general-purpose pins, split into two 8-bit ports. For each port it keeps four registers: a latched input value, an output value, a read-inversion mask and a direction mask. The host writes a command byte that selects one of these eight registers. It then streams data bytes in or out, and the block alternates between the two ports of the selected pair after every byte.

SCL and SDA are sampled on the system clock, synchronized, and passed through a run-length glitch filter before START, STOP and bit edges are decoded. Three strap inputs supply the low bits of the target address, so eight of these blocks can share one bus. An active-low interrupt tells the host that some input pin has moved away from the value last latched into its input register. A host read of that input register latches the pins again and so clears the interrupt.

Top module: `i2c_gpio_expander`

## Requirements
- R1: After reset the output registers hold 8'hFF, the inversion registers 8'h00, the direction registers 8'hFF and the input registers 8'h00. pin_oe_o is all zero, pin_out_o is 16'hFFFF and irq_no is high while the pins are low.
- R2: The block acknowledges only the 7-bit address {4'b0100, strap_i[2:0]} (R/W in bit 0, 0 = write). A transfer to any other address gets no acknowledge and changes no register.
- R3: Bits [2:0] of the command byte select the register: 0/1 input port 0/1, 2/3 output, 4/5 inversion, 6/7 direction. Port p covers pins [8p+7:8p]. Every writable register reads back the last value written to it.
- R4: A direction bit of 1 makes the pin an input (pin_oe_o bit 0). A direction bit of 0 enables the driver, and pin_out_o always shows the output register.
- R5: Each data byte, written or read, toggles bit 0 of the register pointer, so successive bytes alternate between port 0 and port 1 of the selected pair.
- R6: A read of an input register returns the live pins XOR the inversion mask and latches the pins into that register. The inversion mask never changes pin_out_o.
- R7: irq_no goes low when any pin whose direction bit is 1 differs from its latched input bit. Reading the port that holds the difference clears it. Reading the other port does not. Pins set as outputs never raise it.
- R8: A write to an input register is acknowledged and has no effect on the register.
- R9: A read continues while the host acknowledges each byte and ends at the host's NACK, after which the block releases SDA. The block begins driving SDA low only while the filtered SCL is low.
- R10: A pulse shorter than three filter samples on SCL or SDA is ignored. It causes no extra bit, no START and no STOP.
- R11: A STOP returns the block to idle, and a repeated START begins a new address phase. The register pointer keeps its value across transactions, so a read with no command byte starts at the last selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 3 | Low three bits of the target address |
| pin_i | input | 16 | Pin levels, port 1 in [15:8] |
| pin_oe_o | output | 16 | Per-pin output driver enable |
| pin_out_o | output | 16 | Per-pin output value |
| irq_no | output | 1 | Active-low change interrupt (open-drain, low = asserted) |

## Verification
On every cycle the assertions check four things. A direction write reaches the driver enables one cycle later. Each data byte flips only the port bit of the pointer. Input-register writes leave the latched value alone, and an input read latches exactly the synchronized pins. They also check that SDA drive starts only while SCL is low, that a foreign address is never acknowledged, and that the filter moves its output only after an unbroken run of equal samples. Only the bench scenarios can show the rest: the end-to-end byte values, the alternation of ports within a pair, the interrupt being set and cleared per port, a glitch-laden write landing correctly, and the pointer surviving a STOP.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned NPORT = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_INV = 2'd2,
    SEL_DIR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpx_line_filter.sv
module gpx_line_filter #(
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 3,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= {SYNC_LEN{RST_VAL}};
      hist_q  <= {FILT_LEN{RST_VAL}};
      level_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (&hist_q)       level_q <= 1'b1;
      else if (~|hist_q) level_q <= 1'b0;
    end
  end

  assign line_o = level_q;

  // R10: a new level is taken only after a full run of equal samples
  a_r10_filter_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> $past(hist_q) == {FILT_LEN{level_q}});
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
  import gpx_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b0100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       cmd_we_o,
  output logic       data_we_o,
  output logic [7:0] wdata_o,
  output logic       rd_ld_o,
  input  logic [7:0] rd_data_i
);
  bus_state_e state_q;
  logic       scl_q, sda_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q, tx_q;
  logic       rnw_q, mack_q;

  logic scl_rise, scl_fall, start_det, stop_det, byte_done, addr_hit;
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
  assign addr_hit  = (shreg_q[7:1] == {DEV_ID, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      rnw_q     <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_done) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                rnw_q   <= shreg_q[0];
                state_q <= addr_hit ? ST_ADDR_ACK : ST_IDLE;
              end else if (state_q == ST_CMD) begin
                state_q <= ST_CMD_ACK;
              end else begin
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (rnw_q) begin
              tx_q    <= rd_data_i;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_CMD;
            end
          end
          ST_CMD_ACK, ST_WDATA_ACK: if (scl_fall) state_q <= ST_WDATA;
          ST_RDATA: if (scl_fall) begin
            tx_q <= {tx_q[6:0], 1'b0};
            if (bit_cnt_q == 4'd7) begin
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA_ACK;
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) mack_q <= ~sda_i;
            else if (scl_fall) begin
              if (mack_q) begin
                tx_q    <= rd_data_i;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_we_o  = (state_q == ST_CMD) && byte_done;
  assign data_we_o = (state_q == ST_WDATA) && byte_done;
  assign wdata_o   = shreg_q;
  assign rd_ld_o   = scl_fall && (((state_q == ST_ADDR_ACK) && rnw_q) ||
                                  ((state_q == ST_RDATA_ACK) && mack_q));
  assign sda_oe_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_CMD_ACK) ||
                     (state_q == ST_WDATA_ACK) || ((state_q == ST_RDATA) && !tx_q[7]);

  // R9: SDA drive begins only with SCL low
  a_r9_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  // R2: a foreign address is never acknowledged
  a_r2_no_foreign_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && byte_done && !addr_hit) |=> !sda_oe_o);
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
  import gpx_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned NPIN  = NPORT * PORT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  input  logic            cmd_we_i,
  input  logic            data_we_i,
  input  logic [7:0]      wdata_i,
  input  logic            rd_ld_i,
  output logic [7:0]      rd_data_o,
  output logic [NPIN-1:0] pin_oe_o,
  output logic [NPIN-1:0] pin_out_o,
  output logic            irq_no
);
  logic [NPIN-1:0] pin_s1_q;
  logic [NPORT-1:0][PORT_W-1:0] pin_q, in_q, out_q, inv_q, dir_q;
  logic [2:0]      ptr_q;
  logic            irq_n_q;
  reg_sel_e        sel;
  logic            port;

  assign sel  = reg_sel_e'(ptr_q[2:1]);
  assign port = ptr_q[0];

  always_comb begin
    unique case (sel)
      SEL_IN:  rd_data_o = pin_q[port] ^ inv_q[port];
      SEL_OUT: rd_data_o = out_q[port];
      SEL_INV: rd_data_o = inv_q[port];
      default: rd_data_o = dir_q[port];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_s1_q <= '0;
      pin_q    <= '0;
      in_q     <= '0;
      out_q    <= '1;
      inv_q    <= '0;
      dir_q    <= '1;
      ptr_q    <= '0;
      irq_n_q  <= 1'b1;
    end else begin
      pin_s1_q <= pin_i;
      pin_q    <= pin_s1_q;
      irq_n_q  <= ~|((pin_q ^ in_q) & dir_q);
      if (cmd_we_i) ptr_q <= wdata_i[2:0];
      if (data_we_i) begin
        unique case (sel)
          SEL_OUT: out_q[port] <= wdata_i;
          SEL_INV: inv_q[port] <= wdata_i;
          SEL_DIR: dir_q[port] <= wdata_i;
          default: ;
        endcase
        ptr_q[0] <= ~ptr_q[0];
      end
      if (rd_ld_i) begin
        if (sel == SEL_IN) in_q[port] <= pin_q[port];
        ptr_q[0] <= ~ptr_q[0];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign pin_oe_o[p*PORT_W +: PORT_W]  = ~dir_q[p];
    assign pin_out_o[p*PORT_W +: PORT_W] = out_q[p];
  end
  assign irq_no = irq_n_q;

  // R4: a direction write reaches the driver enables on the next cycle
  a_r4_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && ptr_q == 3'd6) |=> pin_oe_o[PORT_W-1:0] == ~$past(wdata_i));
  // R5: every data byte flips only the port bit of the pointer
  a_r5_pair_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i || rd_ld_i) |=> (ptr_q[0] != $past(ptr_q[0])) && (ptr_q[2:1] == $past(ptr_q[2:1])));
  // R6: an input read latches the synchronized pins of that port
  a_r6_input_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ld_i && sel == SEL_IN) |=> in_q[$past(port)] == $past(pin_q[port]));
  // R8: writes aimed at an input register leave it alone
  a_r8_input_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && sel == SEL_IN) |=> $stable(in_q));
endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
  import gpx_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 3,
  parameter logic [3:0]  DEV_ID   = 4'b0100,
  localparam int unsigned NPIN    = NPORT * PORT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [2:0]      strap_i,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_oe_o,
  output logic [NPIN-1:0] pin_out_o,
  output logic            irq_no
);
  logic [1:0] raw, filt;
  logic       cmd_we, data_we, rd_ld;
  logic [7:0] wdata, rd_data;

  assign raw = {scl_i, sda_i};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    gpx_line_filter #(
      .SYNC_LEN(SYNC_LEN),
      .FILT_LEN(FILT_LEN),
      .RST_VAL (1'b1)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[i]),
      .line_o(filt[i])
    );
  end

  gpx_i2c_target #(.DEV_ID(DEV_ID)) u_target (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (filt[1]),
    .sda_i    (filt[0]),
    .strap_i  (strap_i),
    .sda_oe_o (sda_oe_o),
    .cmd_we_o (cmd_we),
    .data_we_o(data_we),
    .wdata_o  (wdata),
    .rd_ld_o  (rd_ld),
    .rd_data_i(rd_data)
  );

  gpx_port_regs #(.PORT_W(PORT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_i),
    .cmd_we_i (cmd_we),
    .data_we_i(data_we),
    .wdata_i  (wdata),
    .rd_ld_i  (rd_ld),
    .rd_data_o(rd_data),
    .pin_oe_o (pin_oe_o),
    .pin_out_o(pin_out_o),
    .irq_no   (irq_no)
  );
endmodule

// File: tb/i2c_gpio_expander_test.sv
module i2c_gpio_expander_test;
  localparam int Q = 16;
  localparam logic [6:0] MY_ADDR = 7'h25;  // 4'b0100 + strap 3'b101

  // {cmd[2:0], value[7:0]}: write, then read back
  localparam logic [10:0] VEC [0:7] = '{
    {3'd2, 8'hA5}, {3'd3, 8'h3C}, {3'd4, 8'h0F}, {3'd5, 8'h81},
    {3'd6, 8'hF0}, {3'd7, 8'h0F}, {3'd0, 8'h12}, {3'd1, 8'hEE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic [15:0] pins = '0;
  logic        sda_oe, irq_n, sda_bus;
  logic [15:0] p_oe, p_out;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_gpio_expander uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .pin_i(pins),
    .pin_oe_o(p_oe), .pin_out_o(p_out), .irq_no(irq_n)
  );

  int  errs = 0, checks = 0;
  bit  done = 1'b0;
  logic [7:0] m_out [2], m_inv [2], m_dir [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic tx_bit(input logic b, input bit gl);
    sda_m = b;
    if (gl) begin
      wt(4); scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(Q - 6);
      scl_m = 1'b1; wt(4);
      if (b) begin sda_m = 1'b0; wt(2); sda_m = 1'b1; wt(2*Q - 6); end
      else wt(2*Q - 4);
    end else begin
      wt(Q); scl_m = 1'b1; wt(2*Q);
    end
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic rx_bit(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_bus; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit gl, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) tx_bit(b[i], gl);
    rx_bit(x);
    ack = ~x;
  endtask

  task automatic rx_byte(output logic [7:0] b, input bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin rx_bit(x); b[i] = x; end
    tx_bit(~ack, 1'b0);
  endtask

  task automatic wr(input logic [2:0] c, input logic [7:0] d0, input logic [7:0] d1, input int n, input bit gl);
    bit ack;
    bus_start;
    tx_byte({MY_ADDR, 1'b0}, 1'b0, ack);
    chk(ack, "R2 own address write ack", ack, 1);
    tx_byte({5'd0, c}, 1'b0, ack);
    tx_byte(d0, gl, ack);
    if (n > 1) tx_byte(d1, 1'b0, ack);
    bus_stop;
  endtask

  task automatic rd(input logic [2:0] c, input int n, output logic [7:0] r0, output logic [7:0] r1);
    bit ack;
    bus_start;
    tx_byte({MY_ADDR, 1'b0}, 1'b0, ack);
    tx_byte({5'd0, c}, 1'b0, ack);
    bus_start;
    tx_byte({MY_ADDR, 1'b1}, 1'b0, ack);
    chk(ack, "R2 own address read ack", ack, 1);
    rx_byte(r0, n > 1);
    r1 = '0;
    if (n > 1) rx_byte(r1, 1'b0);
    bus_stop;
  endtask

  task automatic mwr(input logic [2:0] c, input logic [7:0] d);
    case (c[2:1])
      2'd1: m_out[c[0]] = d;
      2'd2: m_inv[c[0]] = d;
      2'd3: m_dir[c[0]] = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] mexp(input logic [2:0] c);
    case (c[2:1])
      2'd0: return (c[0] ? pins[15:8] : pins[7:0]) ^ m_inv[c[0]];
      2'd1: return m_out[c[0]];
      2'd2: return m_inv[c[0]];
      default: return m_dir[c[0]];
    endcase
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog expired (all requirements) act=hung exp=finished");
      summary;
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1;
    logic [2:0] c;
    bit ack;
    for (int p = 0; p < 2; p++) begin m_out[p] = 8'hFF; m_inv[p] = 8'h00; m_dir[p] = 8'hFF; end
    wt(5); rst_n = 1'b1; wt(20);

    // R1 reset state
    chk(p_oe == 16'h0000, "R1 pin_oe after reset", p_oe, 0);
    chk(p_out == 16'hFFFF, "R1 pin_out after reset", p_out, 16'hFFFF);
    chk(irq_n == 1'b1, "R1 irq idle after reset", irq_n, 1);
    rd(3'd6, 2, r0, r1); chk({r1, r0} == 16'hFFFF, "R1 direction default", {r1, r0}, 16'hFFFF);
    rd(3'd2, 2, r0, r1); chk({r1, r0} == 16'hFFFF, "R1 output default", {r1, r0}, 16'hFFFF);
    rd(3'd4, 2, r0, r1); chk({r1, r0} == 16'h0000, "R1 inversion default", {r1, r0}, 0);

    // R3/R8 vector table: write, read back
    pins = 16'h5AC3; wt(10);
    for (int i = 0; i < 8; i++) begin
      c = VEC[i][10:8];
      wr(c, VEC[i][7:0], 8'h00, 1, 1'b0);
      mwr(c, VEC[i][7:0]);
      rd(c, 1, r0, r1);
      if (c[2:1] == 2'd0) chk(r0 == mexp(c), "R8 input write ignored", r0, mexp(c));
      else                chk(r0 == mexp(c), "R3 register readback", r0, mexp(c));
    end
    wt(10);
    chk(p_oe == ~{m_dir[1], m_dir[0]}, "R4 enables follow direction", p_oe, ~{m_dir[1], m_dir[0]});
    chk(p_out == {m_out[1], m_out[0]}, "R6 pin_out unaffected by inversion", p_out, {m_out[1], m_out[0]});

    // R5 pair alternation on write and read
    wr(3'd2, 8'h11, 8'h22, 2, 1'b0); mwr(3'd2, 8'h11); mwr(3'd3, 8'h22);
    rd(3'd3, 2, r0, r1);
    chk(r0 == 8'h22, "R5 read pair first byte port1", r0, 8'h22);
    chk(r1 == 8'h11, "R5 read pair second byte port0", r1, 8'h11);

    // R6 inverted input read
    rd(3'd0, 2, r0, r1);
    chk(r0 == mexp(3'd0), "R6 input0 inverted", r0, mexp(3'd0));
    chk(r1 == mexp(3'd1), "R6 input1 inverted", r1, mexp(3'd1));

    // R11 pointer kept across STOP; R9 release after NACK
    bus_start; tx_byte({MY_ADDR, 1'b0}, 1'b0, ack); tx_byte(8'd4, 1'b0, ack); bus_stop;
    bus_start; tx_byte({MY_ADDR, 1'b1}, 1'b0, ack); rx_byte(r0, 1'b0);
    wt(2);
    chk(sda_oe == 1'b0, "R9 SDA released after NACK", sda_oe, 0);
    bus_stop;
    chk(r0 == m_inv[0], "R11 pointer kept across STOP", r0, m_inv[0]);

    // R2 foreign address
    bus_start; tx_byte({7'h24, 1'b0}, 1'b0, ack);
    chk(!ack, "R2 foreign address not acked", ack, 0);
    tx_byte(8'd2, 1'b0, ack); tx_byte(8'h00, 1'b0, ack); bus_stop;
    rd(3'd2, 1, r0, r1); chk(r0 == m_out[0], "R2 foreign write no effect", r0, m_out[0]);

    // R10 glitches on SCL and SDA during a write
    wr(3'd2, 8'hB6, 8'h00, 1, 1'b1); mwr(3'd2, 8'hB6);
    rd(3'd2, 1, r0, r1); chk(r0 == 8'hB6, "R10 glitches filtered", r0, 8'hB6);

    // R7 interrupt set, per-port clear, output pins excluded
    wr(3'd6, 8'hFF, 8'hFF, 2, 1'b0); mwr(3'd6, 8'hFF); mwr(3'd7, 8'hFF);
    pins = 16'h0000; wt(10);
    rd(3'd0, 2, r0, r1); wt(10);
    chk(irq_n == 1'b1, "R7 irq idle after latch", irq_n, 1);
    pins = 16'h0200; wt(10);
    chk(irq_n == 1'b0, "R7 irq on port1 change", irq_n, 0);
    rd(3'd0, 1, r0, r1); wt(10);
    chk(irq_n == 1'b0, "R7 port0 read keeps irq", irq_n, 0);
    rd(3'd1, 1, r0, r1); wt(10);
    chk(r0 == mexp(3'd1), "R6 port1 read value", r0, mexp(3'd1));
    chk(irq_n == 1'b1, "R7 port1 read clears irq", irq_n, 1);
    wr(3'd6, 8'hFE, 8'h00, 1, 1'b0);
    pins = 16'h0201; wt(10);
    chk(irq_n == 1'b1, "R7 output pin excluded", irq_n, 1);

    if (!done) begin
      done = 1'b1;
      summary;
      $finish;
    end
  end
endmodule